// File: doc/BRIEF.md
# Issue Queue with Retire-Driven Operand Source Rebinding

This block holds instructions waiting to issue. Each source operand slot keeps two names side by side: an architectural register number and a reorder-buffer tag. A one-bit selector says which of the two the operand currently reads. When an operand's producer is still in flight, the selector is set to the tag at allocation.

When the reorder buffer retires results, it broadcasts the retired tags, up to `RET_LANES` per cycle. Every queued operand whose stored tag matches flips its selector over to the register field. Operands are never rewritten. A dispatched instruction goes through the same comparison on its way out, so an operand whose producer retires in the dispatch cycle already reports the register file as its source.

Allocation takes the lowest-numbered free slot. Dispatch reads and frees a slot chosen by index.

Top module: `iq_rebind`

## Requirements
- R1: While reset is asserted and after it is released with no traffic, every entry reads invalid (`ent_valid` all zero), every `ent_rf` bit reads 0, and `free_count` equals `DEPTH`.
- R2: `alloc_ok` is 1 in the cycle of `alloc_req` exactly when at least one entry is invalid. `alloc_idx` then names the lowest-numbered invalid entry, and that entry becomes valid on the next clock holding the supplied register numbers and tags. With no invalid entry, `alloc_ok` is 0 and no entry changes.
- R3: At allocation, an operand with `alloc_use_tag` bit 1 is stored selecting its tag (`ent_rf` bit 0). An operand with `alloc_use_tag` bit 0 is stored selecting its register (`ent_rf` bit 1). `ent_rf` bit `e*NSRC+s` describes operand `s` of entry `e`.
- R4: A retire broadcast flips, on the next clock, every valid tag-selecting operand whose stored tag equals the broadcast tag to select its register. Tag-selecting operands with other tags keep selecting their tag.
- R5: All `RET_LANES` lanes are compared in parallel. Lane `l` carries `ret_valid[l]` and tag `ret_tag[l*TAGW +: TAGW]`, and a match on any valid lane flips an operand.
- R6: If an allocated operand with `alloc_use_tag` 1 carries a tag that is being broadcast in the same cycle, the entry is written already selecting its register.
- R7: With `disp_req` and a valid entry at `disp_idx`, `disp_ok` is 1 in the same cycle, `disp_reg` and `disp_tag` show that entry's stored names, and the entry reads invalid after the next clock. A request naming an invalid entry gives `disp_ok` 0 and changes nothing.
- R8: During a dispatch, `disp_rf[s]` is 1 when operand `s` selects its register or when its stored tag is being broadcast in that same cycle.
- R9: An operand selecting its register keeps doing so for as long as its entry stays valid, whatever is broadcast.
- R10: `free_count` equals `DEPTH` minus the number of valid entries, and a cycle with both an allocation and a dispatch leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Request to insert an instruction |
| alloc_reg | input | NSRC*REGW | Register numbers, operand s at s*REGW |
| alloc_tag | input | NSRC*TAGW | Reorder-buffer tags, operand s at s*TAGW |
| alloc_use_tag | input | NSRC | 1: operand's producer is in flight |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_idx | output | $clog2(DEPTH) | Entry receiving the allocation |
| ret_valid | input | RET_LANES | Per-lane retire broadcast valid |
| ret_tag | input | RET_LANES*TAGW | Per-lane retired tag |
| disp_req | input | 1 | Request to dispatch an entry |
| disp_idx | input | $clog2(DEPTH) | Entry to dispatch |
| disp_ok | output | 1 | Dispatch accepted this cycle |
| disp_reg | output | NSRC*REGW | Register numbers of the dispatched entry |
| disp_tag | output | NSRC*TAGW | Tags of the dispatched entry |
| disp_rf | output | NSRC | 1: operand reads the register file, 0: reorder buffer |
| ent_valid | output | DEPTH | Per-entry valid |
| ent_rf | output | DEPTH*NSRC | Per-operand register-select, 0 for invalid entries |
| free_count | output | $clog2(DEPTH+1) | Number of invalid entries |

## Verification
Directed sequences cover several cases. Filling the queue and then requesting once more separates correct full detection from slot overwrite. A single-lane broadcast over tags shared by one entry shows that exactly the matching operands move while others stay. Two lanes firing together show whether the lanes are ORed or one masks the other. A broadcast that coincides with an allocation, or with a dispatch, of the same tag separates a design that forwards the broadcast from one that misses it by a cycle. Random traffic over a narrow tag range then produces frequent multi-entry matches, simultaneous allocate and dispatch, and repeated broadcasts of already-retired tags, all checked against a bench model.

// File: rtl/iq_rebind_pkg.sv
package iq_rebind_pkg;
   typedef enum logic {
      SEL_REG = 1'b0,
      SEL_TAG = 1'b1
   } opnd_sel_e;
endpackage

// File: rtl/iq_tag_hit.sv
module iq_tag_hit #(
   parameter int TAGW      = 4,
   parameter int RET_LANES = 2
) (
   input  logic [TAGW-1:0]           tag,
   input  logic [RET_LANES-1:0]      ret_valid,
   input  logic [RET_LANES*TAGW-1:0] ret_tag,
   output logic                      hit
);
   logic [RET_LANES-1:0] lane_hit;

   generate
      if (RET_LANES == 1) begin : g_single
         assign lane_hit[0] = ret_valid[0] && (ret_tag == tag);
      end else begin : g_multi
         for (genvar l = 0; l < RET_LANES; l++) begin : g_lane
            assign lane_hit[l] = ret_valid[l] && (ret_tag[l*TAGW +: TAGW] == tag);
         end
      end
   endgenerate

   assign hit = |lane_hit;
endmodule

// File: rtl/iq_free_pick.sv
module iq_free_pick #(
   parameter int DEPTH = 8
) (
   input  logic [DEPTH-1:0]             valid,
   output logic                         any_free,
   output logic [$clog2(DEPTH)-1:0]     pick_idx,
   output logic [$clog2(DEPTH+1)-1:0]   free_count
);
   localparam int IDXW = $clog2(DEPTH);
   localparam int CNTW = $clog2(DEPTH + 1);

   always_comb begin
      pick_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid[i]) pick_idx = IDXW'(i);
      end
   end

   always_comb begin
      free_count = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!valid[i]) free_count = free_count + CNTW'(1);
      end
   end

   assign any_free = ~&valid;
endmodule

// File: rtl/iq_entry.sv
module iq_entry #(
   parameter int NSRC      = 2,
   parameter int REGW      = 5,
   parameter int TAGW      = 4,
   parameter int RET_LANES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [NSRC*REGW-1:0]      wr_reg,
   input  logic [NSRC*TAGW-1:0]      wr_tag,
   input  logic [NSRC-1:0]           wr_sel_tag,
   input  logic                      clr,
   input  logic [RET_LANES-1:0]      ret_valid,
   input  logic [RET_LANES*TAGW-1:0] ret_tag,
   output logic                      valid_o,
   output logic [NSRC*REGW-1:0]      reg_o,
   output logic [NSRC*TAGW-1:0]      tag_o,
   output logic [NSRC-1:0]           sel_tag_o
);
   logic                 valid_q;
   logic [NSRC*REGW-1:0] reg_q;
   logic [NSRC*TAGW-1:0] tag_q;
   logic [NSRC-1:0]      sel_q;
   logic [NSRC-1:0]      hit;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_opnd
         iq_tag_hit #(.TAGW(TAGW), .RET_LANES(RET_LANES)) u_hit (
            .tag       (tag_q[s*TAGW +: TAGW]),
            .ret_valid (ret_valid),
            .ret_tag   (ret_tag),
            .hit       (hit[s])
         );

         // R4: a matching broadcast moves a tag-selecting operand to its register
         p_flip_on_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && sel_q[s] && hit[s] && !wr_en) |=> !sel_q[s]);
         // R4: no match, the tag stays selected
         p_tag_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && sel_q[s] && !hit[s] && !wr_en && !clr) |=> sel_q[s]);
         // R9: register selection never reverts while valid
         p_reg_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q && !sel_q[s] && !wr_en) |=> !sel_q[s]);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         reg_q   <= '0;
         tag_q   <= '0;
         sel_q   <= '0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
         reg_q   <= wr_reg;
         tag_q   <= wr_tag;
         sel_q   <= wr_sel_tag;
      end else begin
         if (clr) valid_q <= 1'b0;
         for (int s = 0; s < NSRC; s++) begin
            if (sel_q[s] && hit[s]) sel_q[s] <= 1'b0;
         end
      end
   end

   // R2: allocation only ever lands in a free slot
   p_no_overwrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !valid_q);
   // R7: a dispatched entry is released
   p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !wr_en) |=> !valid_q);

   assign valid_o   = valid_q;
   assign reg_o     = reg_q;
   assign tag_o     = tag_q;
   assign sel_tag_o = sel_q;
endmodule

// File: rtl/iq_rebind.sv
module iq_rebind
   import iq_rebind_pkg::*;
#(
   parameter int DEPTH     = 8,
   parameter int NSRC      = 2,
   parameter int REGW      = 5,
   parameter int TAGW      = 4,
   parameter int RET_LANES = 2
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           alloc_req,
   input  logic [NSRC*REGW-1:0]           alloc_reg,
   input  logic [NSRC*TAGW-1:0]           alloc_tag,
   input  logic [NSRC-1:0]                alloc_use_tag,
   output logic                           alloc_ok,
   output logic [$clog2(DEPTH)-1:0]       alloc_idx,
   input  logic [RET_LANES-1:0]           ret_valid,
   input  logic [RET_LANES*TAGW-1:0]      ret_tag,
   input  logic                           disp_req,
   input  logic [$clog2(DEPTH)-1:0]       disp_idx,
   output logic                           disp_ok,
   output logic [NSRC*REGW-1:0]           disp_reg,
   output logic [NSRC*TAGW-1:0]           disp_tag,
   output logic [NSRC-1:0]                disp_rf,
   output logic [DEPTH-1:0]               ent_valid,
   output logic [DEPTH*NSRC-1:0]          ent_rf,
   output logic [$clog2(DEPTH+1)-1:0]     free_count
);
   localparam int IDXW = $clog2(DEPTH);
   localparam logic [IDXW:0] DEPTH_V = DEPTH[IDXW:0];

   generate
      if (DEPTH < 2 || NSRC < 1 || REGW < 1 || TAGW < 1 || RET_LANES < 1) begin : g_bad_param
         $error("iq_rebind: DEPTH must be >= 2 and all widths/counts >= 1");
      end
   endgenerate

   logic [NSRC*REGW-1:0] e_reg [DEPTH];
   logic [NSRC*TAGW-1:0] e_tag [DEPTH];
   logic [NSRC-1:0]      e_sel [DEPTH];
   logic [NSRC-1:0]      alloc_hit;
   logic [NSRC-1:0]      alloc_sel;
   logic [NSRC-1:0]      disp_hit;
   logic [NSRC-1:0]      disp_sel;
   logic                 any_free;
   logic                 idx_in_range;

   iq_free_pick #(.DEPTH(DEPTH)) u_pick (
      .valid      (ent_valid),
      .any_free   (any_free),
      .pick_idx   (alloc_idx),
      .free_count (free_count)
   );

   assign alloc_ok = alloc_req && any_free;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         // allocation path sees the broadcast of the same cycle
         iq_tag_hit #(.TAGW(TAGW), .RET_LANES(RET_LANES)) u_alloc_hit (
            .tag       (alloc_tag[s*TAGW +: TAGW]),
            .ret_valid (ret_valid),
            .ret_tag   (ret_tag),
            .hit       (alloc_hit[s])
         );
         assign alloc_sel[s] = (alloc_use_tag[s] && !alloc_hit[s]) ? SEL_TAG : SEL_REG;

         // dispatch path repeats the comparison on the leaving operand
         iq_tag_hit #(.TAGW(TAGW), .RET_LANES(RET_LANES)) u_disp_hit (
            .tag       (disp_tag[s*TAGW +: TAGW]),
            .ret_valid (ret_valid),
            .ret_tag   (ret_tag),
            .hit       (disp_hit[s])
         );
         assign disp_rf[s] = (disp_sel[s] == SEL_REG) || disp_hit[s];
      end

      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         iq_entry #(.NSRC(NSRC), .REGW(REGW), .TAGW(TAGW), .RET_LANES(RET_LANES)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (alloc_ok && (alloc_idx == IDXW'(e))),
            .wr_reg     (alloc_reg),
            .wr_tag     (alloc_tag),
            .wr_sel_tag (alloc_sel),
            .clr        (disp_ok && (disp_idx == IDXW'(e))),
            .ret_valid  (ret_valid),
            .ret_tag    (ret_tag),
            .valid_o    (ent_valid[e]),
            .reg_o      (e_reg[e]),
            .tag_o      (e_tag[e]),
            .sel_tag_o  (e_sel[e])
         );
         assign ent_rf[e*NSRC +: NSRC] = ent_valid[e] ? ~e_sel[e] : '0;
      end
   endgenerate

   assign idx_in_range = ({1'b0, disp_idx} < DEPTH_V);
   assign disp_ok      = disp_req && idx_in_range && ent_valid[disp_idx];
   assign disp_reg     = e_reg[disp_idx];
   assign disp_tag     = e_tag[disp_idx];
   assign disp_sel     = e_sel[disp_idx];

   // R10: an allocation without a dispatch takes exactly one slot
   p_free_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_ok && !disp_ok) |=> (free_count == $past(free_count) - 1'b1));
   // R10: a dispatch without an allocation returns exactly one slot
   p_free_inc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_ok && !alloc_ok) |=> (free_count == $past(free_count) + 1'b1));
   // R2: a full queue refuses allocation
   p_full_refuse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (free_count == '0) |-> !alloc_ok);
endmodule

// File: tb/iq_rebind_test.sv
`timescale 1ns/1ps
module iq_rebind_test;
   localparam int DEPTH = 8, NSRC = 2, REGW = 5, TAGW = 4, RL = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_req = 1'b0;
   logic [NSRC*REGW-1:0] alloc_reg = '0;
   logic [NSRC*TAGW-1:0] alloc_tag = '0;
   logic [NSRC-1:0] alloc_use_tag = '0;
   logic alloc_ok;
   logic [2:0] alloc_idx;
   logic [RL-1:0] ret_valid = '0;
   logic [RL*TAGW-1:0] ret_tag = '0;
   logic disp_req = 1'b0;
   logic [2:0] disp_idx = '0;
   logic disp_ok;
   logic [NSRC*REGW-1:0] disp_reg;
   logic [NSRC*TAGW-1:0] disp_tag;
   logic [NSRC-1:0] disp_rf;
   logic [DEPTH-1:0] ent_valid;
   logic [DEPTH*NSRC-1:0] ent_rf;
   logic [3:0] free_count;

   iq_rebind #(.DEPTH(DEPTH), .NSRC(NSRC), .REGW(REGW), .TAGW(TAGW), .RET_LANES(RL)) uut (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_reg(alloc_reg),
      .alloc_tag(alloc_tag), .alloc_use_tag(alloc_use_tag), .alloc_ok(alloc_ok),
      .alloc_idx(alloc_idx), .ret_valid(ret_valid), .ret_tag(ret_tag),
      .disp_req(disp_req), .disp_idx(disp_idx), .disp_ok(disp_ok),
      .disp_reg(disp_reg), .disp_tag(disp_tag), .disp_rf(disp_rf),
      .ent_valid(ent_valid), .ent_rf(ent_rf), .free_count(free_count));

   always #10 clk = ~clk;

   int checks = 0, fails = 0;
   bit done = 0;

   bit             m_valid [DEPTH];
   logic [REGW-1:0] m_reg   [DEPTH][NSRC];
   logic [TAGW-1:0] m_tag   [DEPTH][NSRC];
   bit             m_seltag [DEPTH][NSRC];

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit bcast_hit(logic [TAGW-1:0] t);
      bit h = 0;
      for (int l = 0; l < RL; l++)
         if (ret_valid[l] && ret_tag[l*TAGW +: TAGW] == t) h = 1;
      return h;
   endfunction

   function automatic int lowest_free();
      for (int e = 0; e < DEPTH; e++) if (!m_valid[e]) return e;
      return -1;
   endfunction

   // state outputs: R1 at reset, R3/R4/R9 select bits, R10 count
   task automatic check_state(string req);
      int nfree = 0;
      for (int e = 0; e < DEPTH; e++) begin
         chk(req, $sformatf("ent_valid[%0d]", e), int'(ent_valid[e]), int'(m_valid[e]));
         for (int s = 0; s < NSRC; s++)
            chk(req, $sformatf("ent_rf[%0d.%0d]", e, s), int'(ent_rf[e*NSRC+s]),
                int'(m_valid[e] && !m_seltag[e][s]));
         if (!m_valid[e]) nfree++;
      end
      chk("R10", "free_count", int'(free_count), nfree);
   endtask

   // one clock: inputs already driven just after a falling edge
   task automatic cycle(string req);
      int fi;
      bit aok, dok;
      int di;
      #1;
      fi  = lowest_free();
      aok = alloc_req && (fi >= 0);
      chk("R2", "alloc_ok", int'(alloc_ok), int'(aok));
      if (aok) chk("R2", "alloc_idx", int'(alloc_idx), fi);
      di  = int'(disp_idx);
      dok = disp_req && m_valid[di];
      chk("R7", "disp_ok", int'(disp_ok), int'(dok));
      if (dok) begin
         for (int s = 0; s < NSRC; s++) begin
            chk("R7", "disp_reg", int'(disp_reg[s*REGW +: REGW]), int'(m_reg[di][s]));
            chk("R7", "disp_tag", int'(disp_tag[s*TAGW +: TAGW]), int'(m_tag[di][s]));
            chk("R8", "disp_rf", int'(disp_rf[s]),
                int'(!m_seltag[di][s] || bcast_hit(m_tag[di][s])));
         end
      end
      // model update using this cycle's inputs
      for (int e = 0; e < DEPTH; e++)
         if (m_valid[e])
            for (int s = 0; s < NSRC; s++)
               if (m_seltag[e][s] && bcast_hit(m_tag[e][s])) m_seltag[e][s] = 0;
      if (dok) m_valid[di] = 0;
      if (aok) begin
         m_valid[fi] = 1;
         for (int s = 0; s < NSRC; s++) begin
            m_reg[fi][s]    = alloc_reg[s*REGW +: REGW];
            m_tag[fi][s]    = alloc_tag[s*TAGW +: TAGW];
            m_seltag[fi][s] = alloc_use_tag[s] && !bcast_hit(alloc_tag[s*TAGW +: TAGW]);
         end
      end
      @(posedge clk);
      @(negedge clk);
      check_state(req);
   endtask

   task automatic idle();
      alloc_req = 0; alloc_use_tag = '0; ret_valid = '0; disp_req = 0;
   endtask

   task automatic set_alloc(logic [4:0] r0, logic [3:0] t0, bit u0,
                            logic [4:0] r1, logic [3:0] t1, bit u1);
      alloc_req = 1;
      alloc_reg = {r1, r0};
      alloc_tag = {t1, t0};
      alloc_use_tag = {u1, u0};
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd2024));
      for (int e = 0; e < DEPTH; e++) begin
         m_valid[e] = 0;
         for (int s = 0; s < NSRC; s++) begin m_reg[e][s] = '0; m_tag[e][s] = '0; m_seltag[e][s] = 0; end
      end
      repeat (3) @(negedge clk);
      check_state("R1");               // R1 during reset
      rst_n = 1;
      idle();
      cycle("R1");                     // R1 after release, no traffic

      // fill: op0 waits on tag e, op1 is ready in register (R3)
      for (int e = 0; e < DEPTH; e++) begin
         set_alloc(5'(e), 4'(e), 1, 5'(e + 16), 4'(e + 8), 0);
         cycle("R3");
      end
      set_alloc(5'd1, 4'd1, 1, 5'd2, 4'd2, 1);
      cycle("R2");                     // R2 full queue refuses
      idle();

      ret_valid = 2'b01; ret_tag = {4'd0, 4'd3};
      cycle("R4");                     // R4 single broadcast
      ret_valid = 2'b11; ret_tag = {4'd6, 4'd5};
      cycle("R5");                     // R5 two lanes at once
      idle();
      disp_req = 1; disp_idx = 3'd2;
      cycle("R7");                     // R7 dispatch frees entry 2
      idle();
      set_alloc(5'd9, 4'd9, 1, 5'd10, 4'd10, 1);
      ret_valid = 2'b10; ret_tag = {4'd9, 4'd0};
      cycle("R6");                     // R6 alloc with same-cycle retire
      idle();
      disp_req = 1; disp_idx = 3'd7;
      ret_valid = 2'b01; ret_tag = {4'd0, 4'd7};
      cycle("R8");                     // R8 retire during dispatch
      idle();
      ret_valid = 2'b11; ret_tag = {4'd3, 4'd3};
      cycle("R9");                     // R9 register selection stays
      idle();
      disp_req = 1; disp_idx = 3'd7;
      cycle("R7");                     // R7 dispatch of invalid entry
      idle();

      for (int i = 0; i < 4000; i++) begin
         alloc_req = ($urandom % 2) == 1;
         alloc_reg = NSRC*REGW'($urandom);
         alloc_tag = {1'b0, 3'($urandom), 1'b0, 3'($urandom)};
         alloc_use_tag = 2'($urandom);
         ret_valid = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
         ret_tag = {1'b0, 3'($urandom), 1'b0, 3'($urandom)};
         disp_req = ($urandom % 5) < 2;
         disp_idx = 3'($urandom);
         cycle("R4");
      end
      idle();
      cycle("R10");
      finish_run();
   end
endmodule